// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the synchronous control and data path of a pipelined burst SRAM, built around a small internal array. Each word is 18 bits wide and is split into two 9-bit lanes. Each lane holds 8 data bits and the parity bit that belongs to them. Every rising clock edge is classified as a read, a write, a deselect or an idle edge. The decision depends on two address strobes, three chip enables and the write controls. One strobe comes from a processor, the other from a cache controller.

Write data, the lane mask and the write address are captured into a write register and committed to the array on the following edge. Read data passes through an output register, so it appears one edge after the read address was captured. The output drive flag falls at once when the asynchronous output enable is released or when the write controls request a write, because the data pins then act as inputs. When no strobe is sampled and the block is selected, the edge repeats the access at the held address. A write control sampled on such an edge writes that address, and this is how a write started by the processor strobe is completed.

Top module: `psb_access_ctrl`

## Requirements
- R1: With `gwr_n` low on a write edge, both lanes are written with the full 18-bit word, whatever `bwe_n` and `lane_wr_n` are.
- R2: With `gwr_n` high, `bwe_n` high makes the edge a read. With `bwe_n` low, a lane is written only where its `lane_wr_n` bit is low: bit 0 selects lane a (data bits 8:0) and bit 1 selects lane b (data bits 17:9). If neither bit is low, nothing is written.
- R3: The parity bit of each lane is written and read with that lane: bit 8 with lane a and bit 17 with lane b.
- R4: An edge where `strb_proc_n` and `en0_n` are both low captures `addr` as a read and ignores the write controls. The write controls and data sampled on the next edge, with no strobe, decide whether the captured address is written.
- R5: `strb_proc_n` has no effect while `en0_n` is high. That edge is handled as if no strobe were present.
- R6: With `strb_ctl_n` low, the processor strobe not accepted, all enables active (`en0_n` low, `en1` high, `en2_n` low) and an active write combination, the word at `addr` is written in that single edge. If both strobes are low and the processor strobe is accepted, the processor strobe takes precedence and nothing is written on that edge.
- R7: Data for a read address captured on edge N is on `rdata`, with `rdata_drive` high, after edge N+1.
- R8: A strobe edge with any enable inactive deselects the block. Data already in the output register stays driven for one more cycle, and `rdata_drive` is low after the following edge. After an edge that selects a deselected block, `rdata_drive` stays low for that first cycle.
- R9: `rdata_drive` is low while `oe_n` is high, and also while the write controls request a write. Both take effect without waiting for a clock edge.
- R10: A read captured on the edge right after a write to the same address returns the newly written lanes.
- R11: After a synchronous reset (`rst_n` low), the block is deselected, `rdata_drive` is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| en0_n | input | 1 | Chip enable, active low; also qualifies the processor strobe |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drive | output | 1 | High when `rdata` should drive the bus |

## Verification
Two functions can meet on the same edge: arbitration between the two strobes, and write decoding. The bench drives both strobes low with every enable active and a global write requested, then reads the address back to confirm the array was not touched. A second case also meets on one edge: a processor strobe masked by `en0_n` together with a global write. It must complete as a write at the held address and leave the presented address unchanged, and both addresses are read back to judge it.

// File: rtl/psb_pkg.sv
// Shared types for the pipelined burst SRAM access controller.
// Assumes: one access class per rising clock edge.
package psb_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_DESEL = 2'd3
    } psb_op_e;
endpackage

// File: rtl/psb_wr_decode.sv
// Write-control decoder: converts global write, byte-write enable and the
// per-lane selects into a lane write mask. Global write wins over the rest.
// Assumes: all inputs are active low and sampled synchronously by the caller.
module psb_wr_decode #(
    parameter int LANES = 2
) (
    input  logic             gwr_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_mask,
    output logic             wr_active
);
    // Priority decode of the write controls into a lane mask.
    always_comb begin
        if (!gwr_n) begin
            lane_mask = '1;
        end else if (!bwe_n) begin
            lane_mask = ~lane_wr_n;
        end else begin
            lane_mask = '0;
        end
    end

    // A write is requested when any lane is selected.
    assign wr_active = |lane_mask;
endmodule

// File: rtl/psb_cycle_ctrl.sv
// Cycle controller: classifies each edge from the strobes and chip enables,
// holds the selected state and the access address, and flags pending reads.
// Assumes: the processor strobe is only honoured while en0_n is low and
// wins over the controller strobe; a strobe-less edge while selected
// repeats the access at the held address.
module psb_cycle_ctrl
    import psb_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_proc_n,
    input  logic              strb_ctl_n,
    input  logic              en0_n,
    input  logic              en1,
    input  logic              en2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_active,
    output psb_op_e           op,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              sel_q,
    output logic              rd_pend_q
);
    logic              all_en;
    logic              proc_go;
    logic              ctl_go;
    logic              nxt_sel;
    logic [ADDR_W-1:0] addr_q;

    assign all_en  = !en0_n && en1 && !en2_n;
    assign proc_go = !strb_proc_n && !en0_n;
    assign ctl_go  = !strb_ctl_n && !proc_go;

    // Edge classification with processor strobe priority.
    always_comb begin
        op       = OP_IDLE;
        acc_addr = addr_q;
        nxt_sel  = sel_q;
        if (proc_go) begin
            nxt_sel = all_en;
            if (all_en) begin
                op       = OP_READ;
                acc_addr = addr;
            end else begin
                op = OP_DESEL;
            end
        end else if (ctl_go) begin
            nxt_sel = all_en;
            if (all_en) begin
                op       = wr_active ? OP_WRITE : OP_READ;
                acc_addr = addr;
            end else begin
                op = OP_DESEL;
            end
        end else if (sel_q) begin
            op = wr_active ? OP_WRITE : OP_READ;
        end
    end

    // Holds address, selected state and the read-pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            sel_q     <= 1'b0;
            rd_pend_q <= 1'b0;
        end else begin
            addr_q    <= acc_addr;
            sel_q     <= nxt_sel;
            rd_pend_q <= (op == OP_READ);
        end
    end

    // R8
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!strb_proc_n && !en0_n) || !strb_ctl_n) && !(!en0_n && en1 && !en2_n)
        |=> (!sel_q && !rd_pend_q));

    // R5
    proc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && en0_n && strb_ctl_n && !sel_q) |=> !rd_pend_q);
endmodule

// File: rtl/psb_lane_ram.sv
// Lane-split storage array: one memory per lane with its own write enable,
// a shared write address and a combinational read port.
// Assumes: contents are not reset; software writes before it reads.
module psb_lane_ram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Per-lane write port.
        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/psb_out_stage.sv
// Output stage: registers read data one edge after the read was captured and
// gates the drive flag with the asynchronous output enable and write intent.
// Assumes: rd_pend marks that the previous edge captured a read.
module psb_out_stage #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_pend,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              oe_n,
    input  logic              wr_active,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive
);
    logic [DATA_W-1:0] out_q;
    logic              out_valid_q;

    // Output register load for pending reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q       <= '0;
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= rd_pend;
            if (rd_pend) begin
                out_q <= arr_data;
            end
        end
    end

    assign rdata       = out_q;
    assign rdata_drive = out_valid_q && !oe_n && !wr_active;

    // R7
    out_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_q) |-> $past(rd_pend));
endmodule

// File: rtl/psb_access_ctrl.sv
// Top of the pipelined burst SRAM access controller: ties together write
// decode, cycle control, the write register stage, the lane array and the
// output stage.
// Assumes: writes commit to the array one edge after they are accepted.
module psb_access_ctrl
    import psb_pkg::*;
#(
    parameter  int ADDR_W = 6,
    parameter  int LANES  = 2,
    parameter  int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_proc_n,
    input  logic              strb_ctl_n,
    input  logic              en0_n,
    input  logic              en1,
    input  logic              en2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gwr_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive
);
    logic [LANES-1:0]  lane_mask;
    logic              wr_active;
    psb_op_e           op;
    logic [ADDR_W-1:0] acc_addr;
    logic              sel_q;
    logic              rd_pend_q;
    logic              wr_pend_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;
    logic [LANES-1:0]  wr_mask_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] arr_data;

    psb_wr_decode #(.LANES(LANES)) u_dec (
        .gwr_n     (gwr_n),
        .bwe_n     (bwe_n),
        .lane_wr_n (lane_wr_n),
        .lane_mask (lane_mask),
        .wr_active (wr_active)
    );

    psb_cycle_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .strb_proc_n (strb_proc_n),
        .strb_ctl_n  (strb_ctl_n),
        .en0_n       (en0_n),
        .en1         (en1),
        .en2_n       (en2_n),
        .addr        (addr),
        .wr_active   (wr_active),
        .op          (op),
        .acc_addr    (acc_addr),
        .sel_q       (sel_q),
        .rd_pend_q   (rd_pend_q)
    );

    // Write register stage and read address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend_q <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
            wr_mask_q <= '0;
            rd_addr_q <= '0;
        end else begin
            wr_pend_q <= (op == OP_WRITE);
            rd_addr_q <= acc_addr;
            if (op == OP_WRITE) begin
                wr_addr_q <= acc_addr;
                wr_data_q <= wdata;
                wr_mask_q <= lane_mask;
            end
        end
    end

    psb_lane_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
        .clk     (clk),
        .lane_we (wr_mask_q & {LANES{wr_pend_q}}),
        .waddr   (wr_addr_q),
        .wdata   (wr_data_q),
        .raddr   (rd_addr_q),
        .rdata   (arr_data)
    );

    psb_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_pend     (rd_pend_q),
        .arr_data    (arr_data),
        .oe_n        (oe_n),
        .wr_active   (wr_active),
        .rdata       (rdata),
        .rdata_drive (rdata_drive)
    );

    // R1
    gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n && strb_proc_n && !en0_n && en1 && !en2_n && !gwr_n)
        |=> (wr_pend_q && (&wr_mask_q)));

    // R4
    proc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && !en0_n) |=> !wr_pend_q);

    // R11
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!sel_q && !rdata_drive));
endmodule

// File: tb/sim_psb_access_ctrl.sv
// Directed bench for psb_access_ctrl: one task per scenario.
module sim_psb_access_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strb_proc_n, strb_ctl_n, en0_n, en1, en2_n;
    logic [5:0]  addr;
    logic        gwr_n, bwe_n, oe_n;
    logic [1:0]  lane_wr_n;
    logic [17:0] wdata;
    logic [17:0] rdata;
    logic        rdata_drive;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psb_access_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n),
        .en0_n(en0_n), .en1(en1), .en2_n(en2_n), .addr(addr), .gwr_n(gwr_n),
        .bwe_n(bwe_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        strb_proc_n = 1'b1; strb_ctl_n = 1'b1;
        en0_n = 1'b0; en1 = 1'b1; en2_n = 1'b0;
        gwr_n = 1'b1; bwe_n = 1'b1; lane_wr_n = 2'b11; oe_n = 1'b0;
        wdata = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cwrite(input logic [5:0] a, input logic [17:0] d,
                          input logic gw, input logic bw, input logic [1:0] ln);
        strb_ctl_n = 1'b0; addr = a; wdata = d; gwr_n = gw; bwe_n = bw; lane_wr_n = ln;
        tick();
        idle_in();
    endtask

    task automatic cread(input logic [5:0] a);
        strb_ctl_n = 1'b0; addr = a;
        tick();
        idle_in();
        tick();
    endtask

    task automatic t_reset();
        chk("R11 drive", {17'd0, rdata_drive}, 18'd0);
        chk("R11 data", rdata, 18'd0);
    endtask

    task automatic t_global();
        cwrite(6'd5, 18'h2A5A5, 1'b0, 1'b1, 2'b11);
        cread(6'd5);
        chk("R1/R6 global write", rdata, 18'h2A5A5);
        cwrite(6'd5, 18'h15A5A, 1'b0, 1'b0, 2'b10);
        cread(6'd5);
        chk("R1 global overrides lanes", rdata, 18'h15A5A);
    endtask

    task automatic t_byte();
        cwrite(6'd7, 18'h0, 1'b0, 1'b1, 2'b11);
        cwrite(6'd7, 18'h3FFFF, 1'b1, 1'b0, 2'b10);
        cread(6'd7);
        chk("R2/R3 lane a with parity", rdata, {9'h000, 9'h1FF});
        cwrite(6'd7, {9'h155, 9'h000}, 1'b1, 1'b0, 2'b01);
        cread(6'd7);
        chk("R2/R3 lane b with parity", rdata, {9'h155, 9'h1FF});
    endtask

    task automatic t_nowrite();
        cwrite(6'd7, 18'h0, 1'b1, 1'b1, 2'b00);
        cread(6'd7);
        chk("R2 bwe high is read", rdata, {9'h155, 9'h1FF});
        cwrite(6'd7, 18'h0, 1'b1, 1'b0, 2'b11);
        cread(6'd7);
        chk("R2 no lane selected", rdata, {9'h155, 9'h1FF});
    endtask

    task automatic t_proc();
        cwrite(6'd9, 18'h11111, 1'b0, 1'b1, 2'b11);
        cwrite(6'd10, 18'h22222, 1'b0, 1'b1, 2'b11);
        strb_proc_n = 1'b0; addr = 6'd9; gwr_n = 1'b0; wdata = 18'h0;
        tick();
        idle_in(); addr = 6'd10;
        tick();
        cread(6'd9);
        chk("R4 capture edge ignores write", rdata, 18'h11111);
        strb_proc_n = 1'b0; addr = 6'd9;
        tick();
        idle_in(); addr = 6'd10; gwr_n = 1'b0; wdata = 18'h33333;
        tick();
        idle_in();
        cread(6'd9);
        chk("R4 second edge writes captured addr", rdata, 18'h33333);
        cread(6'd10);
        chk("R4 bus address untouched", rdata, 18'h22222);
    endtask

    task automatic t_mask();
        cread(6'd10);
        strb_proc_n = 1'b0; en0_n = 1'b1; addr = 6'd9; gwr_n = 1'b0; wdata = 18'h3C3C3;
        tick();
        idle_in();
        cread(6'd10);
        chk("R5 masked strobe: held addr written", rdata, 18'h3C3C3);
        cread(6'd9);
        chk("R5 masked strobe: new addr unused", rdata, 18'h33333);
    endtask

    task automatic t_prio();
        cwrite(6'd12, 18'h0, 1'b0, 1'b1, 2'b11);
        strb_proc_n = 1'b0; strb_ctl_n = 1'b0; addr = 6'd12; gwr_n = 1'b0; wdata = 18'h12345;
        tick();
        idle_in();
        tick();
        cread(6'd12);
        chk("R6 processor strobe wins", rdata, 18'h0);
    endtask

    task automatic t_latency();
        cwrite(6'd20, 18'h0ABCD, 1'b0, 1'b1, 2'b11);
        cwrite(6'd21, 18'h01111, 1'b0, 1'b1, 2'b11);
        cread(6'd21);
        strb_ctl_n = 1'b0; addr = 6'd20;
        tick();
        idle_in();
        chk("R7 old data one edge after capture", rdata, 18'h01111);
        tick();
        chk("R7 new data after next edge", rdata, 18'h0ABCD);
        chk("R7 driven", {17'd0, rdata_drive}, 18'd1);
    endtask

    task automatic t_desel();
        strb_ctl_n = 1'b0; en2_n = 1'b1;
        tick();
        idle_in();
        chk("R8 still driven after deselect edge", {17'd0, rdata_drive}, 18'd1);
        chk("R8 data held", rdata, 18'h0ABCD);
        tick();
        chk("R8 high-Z after following edge", {17'd0, rdata_drive}, 18'd0);
        strb_ctl_n = 1'b0; addr = 6'd21;
        tick();
        idle_in();
        chk("R8 first selected cycle high-Z", {17'd0, rdata_drive}, 18'd0);
        tick();
        chk("R8 driven on second cycle", {17'd0, rdata_drive}, 18'd1);
        chk("R8 data", rdata, 18'h01111);
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        #1;
        chk("R9 oe high releases", {17'd0, rdata_drive}, 18'd0);
        oe_n = 1'b0;
        #1;
        chk("R9 oe low drives", {17'd0, rdata_drive}, 18'd1);
        gwr_n = 1'b0;
        #1;
        chk("R9 write intent releases", {17'd0, rdata_drive}, 18'd0);
        gwr_n = 1'b1;
        #1;
    endtask

    task automatic t_raw();
        cwrite(6'd30, 18'h0, 1'b0, 1'b1, 2'b11);
        strb_ctl_n = 1'b0; addr = 6'd30; gwr_n = 1'b0; wdata = 18'h2F0F0;
        tick();
        idle_in(); strb_ctl_n = 1'b0; addr = 6'd30;
        tick();
        idle_in();
        tick();
        chk("R10 read right after write", rdata, 18'h2F0F0);
        strb_ctl_n = 1'b0; addr = 6'd30; bwe_n = 1'b0; lane_wr_n = 2'b10;
        wdata = {9'h000, 9'h0A5};
        tick();
        idle_in(); strb_ctl_n = 1'b0; addr = 6'd30;
        tick();
        idle_in();
        tick();
        chk("R10 lane update seen next cycle", rdata, {9'h178, 9'h0A5});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        addr = '0;
        rst_n = 1'b0;
        tick(); tick(); tick();
        rst_n = 1'b1;
        t_reset();
        t_global();
        t_byte();
        t_nowrite();
        t_proc();
        t_mask();
        t_prio();
        t_latency();
        t_desel();
        t_oe();
        t_raw();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule